// File: doc/BRIEF.md
# Dual-Protocol Host Bus Front End

This block sits between a microprocessor bus and the core of a display controller. The host reaches it through an 8-bit data port, one select line, a chip select and strobes. The select line says whether a byte is a command or display data. Two host styles are supported. One uses a read/write line with an active-high enable strobe. The other uses separate active-low read and write strobes. Every captured write becomes a one-cycle internal pulse that carries the byte and a command/data flag. During a host read, the block drives back either a status byte or read data, both supplied by the core.

One input pin, the mode/reset pin, does two jobs. While the system reset is asserted, its level selects the host style: high selects the enable-strobe style and low selects the split-strobe style. After that, an edge on the pin toward the reset level of the chosen style produces a one-cycle core reset pulse. In enable-strobe mode that edge is a fall. In split-strobe mode it is a rise.

Every host input is brought into the clock domain through a two-stage synchronizer before any edge is decoded. The data port is split into an input bus, an output bus and an output-enable signal, which the pad ring turns into a tri-state pin.

Top module: `hostbus_if`

## Requirements
- R1: `bus_oe_o` is 1 only while a read is active. A read is active when `cs_n_i` is 0 and either of these holds:
  - enable-strobe mode with `en_i`=1 and `rw_i`=1;
  - split-strobe mode with `rd_n_i`=0.
  
  At all other times `bus_oe_o` is 0, within 4 clock cycles of the host inputs settling.
- R2: During an active read, `bus_o` carries `status_i` when `sel_i`=0 and `rdata_i` when `sel_i`=1.
- R3: `mode68_o` takes the synchronized level of `mode_rst_i` while `rst` is high: 1 means enable-strobe mode and 0 means split-strobe mode. It does not change again until the next `rst`.
- R4: In enable-strobe mode, a falling edge on `mode_rst_i` gives exactly one one-cycle `core_rst_o` pulse. A rising edge gives none.
- R5: In split-strobe mode, a rising edge on `mode_rst_i` gives exactly one one-cycle `core_rst_o` pulse. A falling edge gives none.
- R6: In enable-strobe mode, a falling edge of `en_i` with `rw_i`=0 and `cs_n_i`=0 gives one `wr_pulse_o`. On that pulse, `wr_byte_o` equals `bus_i` and `wr_is_data_o` equals `sel_i`, as both were held during the strobe (select 0 = command, 1 = display data).
- R7: In split-strobe mode, a rising edge of `wr_n_i` with `cs_n_i`=0 gives one `wr_pulse_o`. `wr_byte_o` and `wr_is_data_o` follow the same rule as in R6.
- R8: While `cs_n_i`=1, no strobe produces a write pulse, and `bus_oe_o` stays 0.
- R9: The strobes that belong to the mode not selected have no effect: they produce no write pulse and no output enable.
- R10: `wr_pulse_o` and `core_rst_o` never stay high for two cycles in a row. A write pulse appears within 6 cycles of its strobe edge. After `rst`, `wr_pulse_o`, `core_rst_o` and `bus_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high system reset; host mode is sampled while high |
| mode_rst_i | input | 1 | Mode level and core-reset edge pin |
| cs_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | 0 = command/status, 1 = display data |
| rw_i | input | 1 | Enable-strobe mode: 1 = read, 0 = write |
| en_i | input | 1 | Enable-strobe mode: active-high enable strobe |
| rd_n_i | input | 1 | Split-strobe mode: read strobe, active low |
| wr_n_i | input | 1 | Split-strobe mode: write strobe, active low |
| bus_i | input | 8 | Data port, pin to core |
| bus_o | output | 8 | Data port, core to pin |
| bus_oe_o | output | 1 | Pad drive enable for the data port |
| status_i | input | 8 | Status byte from the core |
| rdata_i | input | 8 | Display read data from the core |
| wr_pulse_o | output | 1 | One-cycle write strobe to the core |
| wr_is_data_o | output | 1 | Flag on the write: 1 = display data, 0 = command |
| wr_byte_o | output | 8 | Byte written by the host |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| mode68_o | output | 1 | 1 = enable-strobe mode, 0 = split-strobe mode |

## Verification
Some internal faults show up at the ports a few cycles after a strobe edge:
- A wrong latched mode makes the whole protocol set disappear: writes from the expected style give no pulse, and strobes of the other style start producing traffic.
- A stale delayed copy of the strobes or the pin shows up as a missing, doubled or extra pulse within about four cycles of the edge.
- A wrong captured select or data register shows up as a mismatched byte or flag on the very pulse that carries it.

Each write and each reset pulse is compared as it appears, so a fault surfaces on the first transaction that touches it.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic {
    HOST_SPLIT = 1'b0,
    HOST_ENSTB = 1'b1
  } host_mode_e;

  localparam int CTRL_W = 7;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hbi_rstdet.sv
module hbi_rstdet
  import hbi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic mode68_o,
  output logic core_rst_o
);
  host_mode_e mode_q;
  logic       pin_d;
  logic       pulse_q;

  always_ff @(posedge clk) pin_d <= pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= host_mode_e'(pin_s);
      pulse_q <= 1'b0;
    end else if (mode_q == HOST_ENSTB) begin
      pulse_q <= pin_d & ~pin_s;
    end else begin
      pulse_q <= ~pin_d & pin_s;
    end
  end

  assign mode68_o   = (mode_q == HOST_ENSTB);
  assign core_rst_o = pulse_q;

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode_q));
  // R10
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R4 R5
  rst_level_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (pin_d == (mode_q == HOST_SPLIT)));
endmodule

// File: rtl/hbi_strobe.sv
module hbi_strobe #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode68,
  input  logic          cs_n_s,
  input  logic          rw_s,
  input  logic          en_s,
  input  logic          rd_n_s,
  input  logic          wr_n_s,
  input  logic          sel_s,
  input  logic [DW-1:0] data_s,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata_i,
  output logic          wr_pulse_o,
  output logic          wr_is_data_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          oe_o,
  output logic [DW-1:0] dout_o
);
  logic          cs_n_d, rw_d, en_d, wr_n_d, sel_d;
  logic [DW-1:0] data_d;
  logic          wr_evt, rd_act;
  logic          pulse_q, isdata_q, oe_q;
  logic [DW-1:0] byte_q, dout_q;

  always_ff @(posedge clk) begin
    cs_n_d <= cs_n_s;
    rw_d   <= rw_s;
    en_d   <= en_s;
    wr_n_d <= wr_n_s;
    sel_d  <= sel_s;
    data_d <= data_s;
  end

  always_comb begin
    if (mode68) begin
      wr_evt = !cs_n_d && !rw_d && en_d && !en_s;
      rd_act = !cs_n_s && rw_s && en_s;
    end else begin
      wr_evt = !cs_n_d && !wr_n_d && wr_n_s;
      rd_act = !cs_n_s && !rd_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= 1'b0;
      isdata_q <= 1'b0;
      byte_q   <= '0;
      oe_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      pulse_q <= wr_evt;
      if (wr_evt) begin
        isdata_q <= sel_d;
        byte_q   <= data_d;
      end
      oe_q   <= rd_act;
      dout_q <= sel_s ? rdata_i : status_i;
    end
  end

  assign wr_pulse_o   = pulse_q;
  assign wr_is_data_o = isdata_q;
  assign wr_byte_o    = byte_q;
  assign oe_o         = oe_q;
  assign dout_o       = dout_q;

  // R10
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R8
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> !$past(cs_n_s));
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hbi_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_rst_i,
  input  logic          cs_n_i,
  input  logic          sel_i,
  input  logic          rw_i,
  input  logic          en_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata_i,
  output logic          wr_pulse_o,
  output logic          wr_is_data_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          core_rst_o,
  output logic          mode68_o
);
  localparam int SW = DW + CTRL_W;

  logic [SW-1:0] raw, syn;
  logic          mode68;

  assign raw = {mode_rst_i, cs_n_i, sel_i, rw_i, en_i, rd_n_i, wr_n_i, bus_i};

  hbi_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (raw),
    .q_o (syn)
  );

  hbi_rstdet u_rstdet (
    .clk        (clk),
    .rst        (rst),
    .pin_s      (syn[DW+6]),
    .mode68_o   (mode68),
    .core_rst_o (core_rst_o)
  );

  hbi_strobe #(.DW(DW)) u_strobe (
    .clk          (clk),
    .rst          (rst),
    .mode68       (mode68),
    .cs_n_s       (syn[DW+5]),
    .sel_s        (syn[DW+4]),
    .rw_s         (syn[DW+3]),
    .en_s         (syn[DW+2]),
    .rd_n_s       (syn[DW+1]),
    .wr_n_s       (syn[DW]),
    .data_s       (syn[DW-1:0]),
    .status_i     (status_i),
    .rdata_i      (rdata_i),
    .wr_pulse_o   (wr_pulse_o),
    .wr_is_data_o (wr_is_data_o),
    .wr_byte_o    (wr_byte_o),
    .oe_o         (bus_oe_o),
    .dout_o       (bus_o)
  );

  assign mode68_o = mode68;

  // R10
  no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_o |=> !core_rst_o);
endmodule

// File: tb/test_hostbus_if.sv
module test_hostbus_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_rst_i = 1'b0;
  logic       cs_n_i = 1'b1, sel_i = 1'b0, rw_i = 1'b1, en_i = 1'b0;
  logic       rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [7:0] bus_i = '0, status_i = 8'hA5, rdata_i = 8'h3C;
  logic [7:0] bus_o, wr_byte_o;
  logic       bus_oe_o, wr_pulse_o, wr_is_data_o, core_rst_o, mode68_o;

  int total = 0, bad = 0;
  int rst_exp = 0;
  int wr_seen = 0;
  logic [8:0] wq[$];

  always #4 clk = ~clk;

  hostbus_if i_hostbus_if (
    .clk(clk), .rst(rst), .mode_rst_i(mode_rst_i), .cs_n_i(cs_n_i),
    .sel_i(sel_i), .rw_i(rw_i), .en_i(en_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .status_i(status_i),
    .rdata_i(rdata_i), .wr_pulse_o(wr_pulse_o), .wr_is_data_o(wr_is_data_o),
    .wr_byte_o(wr_byte_o), .core_rst_o(core_rst_o), .mode68_o(mode68_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard for write pulses and core reset pulses (R6 R7 R10)
  always @(negedge clk) begin
    if (!rst && wr_pulse_o) begin
      wr_seen++;
      if (wq.size() == 0) chk(0, "R8/R9 unexpected write", {wr_is_data_o, wr_byte_o}, 0);
      else begin
        logic [8:0] e;
        e = wq.pop_front();
        chk({wr_is_data_o, wr_byte_o} == e, "R6/R7 write content", {wr_is_data_o, wr_byte_o}, e);
      end
    end
    if (!rst && core_rst_o) begin
      chk(rst_exp > 0, "R4/R5 core reset pulse", 1, rst_exp);
      if (rst_exp > 0) rst_exp--;
    end
  end

  task automatic sysreset(input logic pin, input logic exp68);
    mode_rst_i = pin;
    rst = 1'b1;
    cyc(6);
    chk(mode68_o == exp68, "R3 mode select", mode68_o, exp68);
    chk(!wr_pulse_o && !core_rst_o && !bus_oe_o, "R10 reset state",
        {wr_pulse_o, core_rst_o, bus_oe_o}, 0);
    rst = 1'b0;
    cyc(3);
  endtask

  task automatic idle();
    cs_n_i = 1'b1; rw_i = 1'b1; en_i = 1'b0; rd_n_i = 1'b1; wr_n_i = 1'b1;
  endtask

  task automatic wr68(input logic sel, input logic [7:0] b, input logic cs_n, input bit expect_it);
    if (expect_it) wq.push_back({sel, b});
    cs_n_i = cs_n; rw_i = 1'b0; sel_i = sel; bus_i = b; cyc(3);
    en_i = 1'b1; cyc(4);
    en_i = 1'b0; cyc(3);
    idle(); sel_i = ~sel; bus_i = ~b; cyc(3);
    chk(wq.size() == 0, "R10 write latency", wq.size(), 0);
  endtask

  task automatic wr80(input logic sel, input logic [7:0] b, input logic cs_n, input bit expect_it);
    if (expect_it) wq.push_back({sel, b});
    cs_n_i = cs_n; sel_i = sel; bus_i = b; cyc(3);
    wr_n_i = 1'b0; cyc(4);
    wr_n_i = 1'b1; cyc(3);
    idle(); sel_i = ~sel; bus_i = ~b; cyc(3);
    chk(wq.size() == 0, "R10 write latency", wq.size(), 0);
  endtask

  task automatic rd(input bit style68, input logic sel, input logic cs_n, input bit expect_oe);
    logic [7:0] e;
    cs_n_i = cs_n; sel_i = sel;
    if (style68) begin rw_i = 1'b1; en_i = 1'b1; end
    else rd_n_i = 1'b0;
    cyc(5);
    chk(bus_oe_o == expect_oe, "R1/R8/R9 output enable", bus_oe_o, expect_oe);
    if (expect_oe) begin
      e = sel ? rdata_i : status_i;
      chk(bus_o == e, "R2 read value", bus_o, e);
    end
    idle(); cyc(5);
    chk(bus_oe_o == 1'b0, "R1 release", bus_oe_o, 0);
  endtask

  task automatic pin_to(input logic v, input bit expect_pulse, input string req);
    if (expect_pulse) rst_exp++;
    mode_rst_i = v; cyc(7);
    chk(rst_exp == 0, req, rst_exp, 0);
  endtask

  initial begin : watchdog
    #1ms;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seen0;
    idle();
    cyc(1);
    // split-strobe mode
    sysreset(1'b0, 1'b0);
    wr80(1'b0, 8'h5A, 1'b0, 1);        // R7 command
    wr80(1'b1, 8'hC3, 1'b0, 1);        // R7 data
    wr80(1'b1, 8'h11, 1'b1, 0);        // R8 deselected
    rd(1'b0, 1'b0, 1'b0, 1);           // R2 status
    rd(1'b0, 1'b1, 1'b0, 1);           // R2 rdata
    rd(1'b0, 1'b1, 1'b1, 0);           // R8 read ignored
    seen0 = wr_seen;
    wr68(1'b1, 8'h77, 1'b0, 0);        // R9 foreign strobe
    rd(1'b1, 1'b0, 1'b0, 0);           // R9 foreign read
    chk(wr_seen == seen0, "R9 no write", wr_seen, seen0);
    pin_to(1'b1, 1, "R5 rising pulse");
    pin_to(1'b0, 0, "R5 falling none");
    chk(mode68_o == 1'b0, "R3 mode held", mode68_o, 0);
    // enable-strobe mode
    sysreset(1'b1, 1'b1);
    wr68(1'b0, 8'h81, 1'b0, 1);        // R6 command
    wr68(1'b1, 8'h2E, 1'b0, 1);        // R6 data
    seen0 = wr_seen;
    wr68(1'b0, 8'h99, 1'b1, 0);        // R8 deselected
    wr80(1'b0, 8'h44, 1'b0, 0);        // R9 foreign strobe
    chk(wr_seen == seen0, "R8/R9 no write", wr_seen, seen0);
    status_i = 8'h0F; rdata_i = 8'hF0;
    rd(1'b1, 1'b0, 1'b0, 1);           // R2 status
    rd(1'b1, 1'b1, 1'b0, 1);           // R2 rdata
    rd(1'b0, 1'b1, 1'b0, 0);           // R9 foreign read
    pin_to(1'b0, 1, "R4 falling pulse");
    chk(mode68_o == 1'b1, "R3 mode held", mode68_o, 1);
    pin_to(1'b1, 0, "R4 rising none");
    chk(wq.size() == 0, "R6/R7 queue drained", wq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule